// File: doc/BRIEF.md
# Branch Target and Execution-Mode Resolver

This block sits in the execute stage of a processor core that can run code from two places: a small local register memory (512 words) or a large shared memory (64K words). Each cycle the core hands it a decoded control-flow request. The request carries an operation, a target kind, a 16-bit immediate, a register operand, the current program counter, the current execution mode and the result of the condition test. One clock later the block presents the next program counter and the next execution mode, with a strobe that marks a taken branch.

No separate opcode picks the execution mode. An absolute target selects the mode from its own value: addresses below 0x0200 run from local memory and all higher addresses run from shared memory. For register targets this test is made at execution time. Relative branches never leave the current mode. Plain calls and returns use a four-entry hardware return stack. Each entry saves the return address together with the mode it came from, so code needs no return labels and no patched return instruction.

Top module: `jump_target_unit`

## Requirements
- R1: After a synchronous active-high reset, `nxt_pc` is 0, `nxt_mode` is 0 (local), `taken` is 0 and `ret_underflow` is 0. The return stack is empty.
- R2: Operation encodings on `req_op`: 00 sequential, 01 jump, 10 call, 11 return. Target kinds on `req_kind`: 00 immediate relative, 01 immediate absolute, 10 register relative, 11 register absolute. Mode 0 is local and mode 1 is shared. For an immediate-relative jump or call, the new PC is `cur_pc` plus `imm`, read as a two's-complement offset. The mode stays `cur_mode` and `taken` is 1.
- R3: For an immediate-absolute jump or call, the new PC is `imm`. The new mode is 0 when `imm` is 0x0000–0x01FF and 1 when it is 0x0200–0xFFFF.
- R4: For a register-relative jump or call, the new PC is `cur_pc` plus `reg_val`, and the mode stays `cur_mode`.
- R5: For a register-absolute jump or call, the new PC is `reg_val`, and the mode is chosen from the range of `reg_val` as in R3. `imm` has no effect.
- R6: In local mode, relative targets and the sequential next address wrap modulo 512. In shared mode they wrap modulo 65536.
- R7: When `cond_ok` is 0, or when the operation is sequential, the new PC is `cur_pc`+1 (wrapped as in R6). The mode is unchanged, `taken` is 0 and the return stack is not changed.
- R8: A taken call pushes {`cur_pc`+1 wrapped as in R6, `cur_mode`}. A taken return pops the most recent entry and restores both its PC and its mode, with `taken` 1.
- R9: A call made while four entries are held discards the oldest entry. The four most recent entries remain, in last-in-first-out order.
- R10: A return with the stack empty gives PC 0 and mode 0, and sets `ret_underflow`. This flag stays 1 until reset.
- R11: All outputs are registered and change on the clock edge after the request. While `req_valid` is 0, `nxt_pc` and `nxt_mode` hold their values and `taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A control-flow request is present this cycle |
| req_op | input | 2 | Operation: sequential, jump, call, return |
| req_kind | input | 2 | Target kind for jump and call |
| imm | input | 16 | Immediate address or offset |
| reg_val | input | 16 | Register operand: offset or address |
| cur_pc | input | 16 | Program counter of the requesting instruction |
| cur_mode | input | 1 | Current execution mode (0 local, 1 shared) |
| cond_ok | input | 1 | Condition test passed |
| nxt_pc | output | 16 | Next program counter |
| nxt_mode | output | 1 | Next execution mode |
| taken | output | 1 | The last request redirected the flow |
| ret_underflow | output | 1 | Sticky flag: a return was made with the stack empty |

## Verification
The directed patterns cover the following cases:
- Absolute targets on both sides of the 0x01FF/0x0200 boundary. These separate a correct range classifier from an off-by-one or an inverted one.
- Relative branches from both modes that cross the 9-bit and 16-bit wrap points. These show whether the correct wrap width is used in each mode.
- Call chains that mix the two modes. These show whether the saved mode travels with the return address.
- A run of five calls followed by five returns. This tells oldest-entry eviction apart from a stack that refuses the new entry, and it reaches the empty-pop and sticky-flag case.
- Failed conditions, idle cycles and register-absolute requests with a misleading immediate. These show that nothing outside the chosen path changes the result.

A long random mix is then compared every cycle against a behavioural model that keeps the stack in a queue.

// File: rtl/jtu_pkg.sv
package jtu_pkg;

  typedef enum logic [1:0] {
    OP_SEQ  = 2'b00,
    OP_JUMP = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } op_e;

  // bit 0: absolute, bit 1: operand from register
  typedef enum logic [1:0] {
    K_IMM_REL = 2'b00,
    K_IMM_ABS = 2'b01,
    K_REG_REL = 2'b10,
    K_REG_ABS = 2'b11
  } kind_e;

endpackage

// File: rtl/jtu_mode_classify.sv
module jtu_mode_classify #(
  parameter int ADDR_W  = 16,
  parameter int LOCAL_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_shared
);
  // An address lies outside local memory when any bit above the local span is set
  generate
    if (LOCAL_W < ADDR_W) begin : g_split
      assign is_shared = |addr[ADDR_W-1:LOCAL_W];
    end else begin : g_all_local
      assign is_shared = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/jtu_target_calc.sv
module jtu_target_calc
  import jtu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LOCAL_W = 9
) (
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] imm,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              cur_mode,
  output logic [ADDR_W-1:0] tgt_pc,
  output logic              tgt_mode,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam int HI_W = ADDR_W - LOCAL_W;

  logic [ADDR_W-1:0]  operand;
  logic [ADDR_W-1:0]  wide_sum;
  logic [LOCAL_W-1:0] local_sum;
  logic [ADDR_W-1:0]  rel_pc;
  logic [ADDR_W-1:0]  wide_inc;
  logic [LOCAL_W-1:0] local_inc;
  logic               abs_shared;

  assign operand   = kind[1] ? reg_val : imm;
  assign wide_sum  = cur_pc + operand;
  assign local_sum = cur_pc[LOCAL_W-1:0] + operand[LOCAL_W-1:0];
  assign wide_inc  = cur_pc + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign local_inc = cur_pc[LOCAL_W-1:0] + {{(LOCAL_W-1){1'b0}}, 1'b1};

  // Relative results keep the width of the current mode
  assign rel_pc = cur_mode ? wide_sum : {{HI_W{1'b0}}, local_sum};
  assign seq_pc = cur_mode ? wide_inc : {{HI_W{1'b0}}, local_inc};

  jtu_mode_classify #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W)) u_classify (
    .addr      (operand),
    .is_shared (abs_shared)
  );

  always_comb begin
    if (kind[0]) begin
      tgt_pc   = operand;
      tgt_mode = abs_shared;
    end else begin
      tgt_pc   = rel_pc;
      tgt_mode = cur_mode;
    end
  end
endmodule

// File: rtl/jtu_ret_stack.sv
module jtu_ret_stack #(
  parameter int ENTRY_W = 17,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] push_data,
  output logic [ENTRY_W-1:0] pop_data,
  output logic               empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // Circular storage: a push on a full stack overwrites the oldest slot
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   top_ptr;
  logic [CNT_W-1:0]   count;

  assign top_ptr = wr_ptr - PTR_W'(1);
  assign empty   = (count == '0);
  assign pop_data = empty ? '0 : mem[top_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (push) begin
      wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (count != FULL_CNT) count <= count + CNT_W'(1);
    end else if (pop && !empty) begin
      wr_ptr <= top_ptr;
      count  <= count - CNT_W'(1);
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);  // R9

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));  // R8

  AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (count == '0));  // R10
endmodule

// File: rtl/jump_target_unit.sv
module jump_target_unit
  import jtu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LOCAL_W     = 9,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] imm,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              cur_mode,
  input  logic              cond_ok,
  output logic [ADDR_W-1:0] nxt_pc,
  output logic              nxt_mode,
  output logic              taken,
  output logic              ret_underflow
);
  localparam int ENTRY_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] LOCAL_SPAN = ADDR_W'(1 << LOCAL_W);

  op_e   op;
  kind_e kind;
  assign op   = op_e'(req_op);
  assign kind = kind_e'(req_kind);

  logic [ADDR_W-1:0]  tgt_pc, seq_pc;
  logic               tgt_mode;
  logic               go, do_push, do_pop, stk_empty;
  logic [ENTRY_W-1:0] pop_data;

  logic [ADDR_W-1:0] pc_d;
  logic              mode_d, taken_d, ufl_d;

  assign go      = req_valid && cond_ok;
  assign do_push = go && (op == OP_CALL);
  assign do_pop  = go && (op == OP_RET);

  jtu_target_calc #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W)) u_calc (
    .kind     (kind),
    .imm      (imm),
    .reg_val  (reg_val),
    .cur_pc   (cur_pc),
    .cur_mode (cur_mode),
    .tgt_pc   (tgt_pc),
    .tgt_mode (tgt_mode),
    .seq_pc   (seq_pc)
  );

  jtu_ret_stack #(.ENTRY_W(ENTRY_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .push_data ({seq_pc, cur_mode}),
    .pop_data  (pop_data),
    .empty     (stk_empty)
  );

  always_comb begin
    pc_d    = nxt_pc;
    mode_d  = nxt_mode;
    taken_d = 1'b0;
    ufl_d   = ret_underflow;
    if (req_valid) begin
      if (!cond_ok || op == OP_SEQ) begin
        pc_d   = seq_pc;
        mode_d = cur_mode;
      end else if (op == OP_RET) begin
        pc_d    = pop_data[ENTRY_W-1:1];
        mode_d  = pop_data[0];
        taken_d = 1'b1;
        if (stk_empty) ufl_d = 1'b1;
      end else begin
        pc_d    = tgt_pc;
        mode_d  = tgt_mode;
        taken_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_pc        <= '0;
      nxt_mode      <= 1'b0;
      taken         <= 1'b0;
      ret_underflow <= 1'b0;
    end else begin
      nxt_pc        <= pc_d;
      nxt_mode      <= mode_d;
      taken         <= taken_d;
      ret_underflow <= ufl_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!taken && $stable(nxt_pc) && $stable(nxt_mode)));  // R11

  AST_SKIP_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cond_ok) |=> (!taken && nxt_mode == $past(cur_mode)));  // R7

  AST_REL_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    (go && (op == OP_JUMP || op == OP_CALL) && !req_kind[0])
      |=> (taken && nxt_mode == $past(cur_mode)));  // R2

  AST_ABS_MODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (go && (op == OP_JUMP || op == OP_CALL) && req_kind[0])
      |=> (nxt_mode == (($past(req_kind[1]) ? $past(reg_val) : $past(imm)) >= LOCAL_SPAN)));  // R3

  AST_LOCAL_PC_RANGE: assert property (@(posedge clk) disable iff (rst)
    !nxt_mode |-> (nxt_pc < LOCAL_SPAN));  // R6

  AST_UFL_STICKY: assert property (@(posedge clk) disable iff (rst)
    ret_underflow |=> ret_underflow);  // R10
endmodule

// File: tb/jump_target_unit_test.sv
module jump_target_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] imm = '0, reg_val = '0, cur_pc = '0;
  logic        cur_mode = 1'b0, cond_ok = 1'b0;
  logic [15:0] nxt_pc;
  logic        nxt_mode, taken, ret_underflow;

  always #10 clk = ~clk;  // 50 MHz

  jump_target_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_kind(req_kind), .imm(imm), .reg_val(reg_val), .cur_pc(cur_pc),
    .cur_mode(cur_mode), .cond_ok(cond_ok), .nxt_pc(nxt_pc),
    .nxt_mode(nxt_mode), .taken(taken), .ret_underflow(ret_underflow)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Behavioural reference state
  logic [15:0] m_pc = 0;
  logic        m_mode = 0, m_taken = 0, m_ufl = 0;
  logic [16:0] stk[$];

  function automatic logic [15:0] wrap(input int v, input bit md);
    return md ? 16'(v & 65535) : 16'(v & 511);
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (nxt_pc !== m_pc || nxt_mode !== m_mode || taken !== m_taken || ret_underflow !== m_ufl) begin
      failures++;
      $display("FAIL %s: got pc=%h mode=%0d taken=%0d ufl=%0d expected pc=%h mode=%0d taken=%0d ufl=%0d",
               tag, nxt_pc, nxt_mode, taken, ret_underflow, m_pc, m_mode, m_taken, m_ufl);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] op, input logic [1:0] kind,
                      input logic [15:0] im, input logic [15:0] rv, input logic [15:0] pc,
                      input bit md, input bit c, input string tag);
    logic [15:0] opnd;
    req_valid = v; req_op = op; req_kind = kind; imm = im; reg_val = rv;
    cur_pc = pc; cur_mode = md; cond_ok = c;
    if (!v) begin
      m_taken = 0;
    end else if (!c || op == 2'b00) begin
      m_pc = wrap(int'(pc) + 1, md); m_mode = md; m_taken = 0;
    end else if (op == 2'b11) begin
      m_taken = 1;
      if (stk.size() == 0) begin
        m_pc = 0; m_mode = 0; m_ufl = 1;
      end else begin
        logic [16:0] e;
        e = stk.pop_back();
        m_pc = e[16:1]; m_mode = e[0];
      end
    end else begin
      if (op == 2'b10) begin
        if (stk.size() == 4) void'(stk.pop_front());
        stk.push_back({wrap(int'(pc) + 1, md), md});
      end
      opnd = kind[1] ? rv : im;
      if (kind[0]) begin
        m_pc = opnd; m_mode = (opnd >= 16'h0200);
      end else begin
        m_pc = wrap(int'(pc) + int'(opnd), md); m_mode = md;
      end
      m_taken = 1;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state");

    // R2 immediate relative, both modes, negative offset
    step(1, 2'b01, 2'b00, 16'hFFF0, 16'h0000, 16'h1000, 1, 1, "R2 imm rel shared back");
    step(1, 2'b01, 2'b00, 16'h0005, 16'h0000, 16'h0010, 0, 1, "R2 imm rel local");
    // R3 range boundary
    step(1, 2'b01, 2'b01, 16'h01FF, 16'h0000, 16'h3000, 1, 1, "R3 abs 01FF local");
    step(1, 2'b01, 2'b01, 16'h0200, 16'h0000, 16'h0040, 0, 1, "R3 abs 0200 shared");
    step(1, 2'b01, 2'b01, 16'h0000, 16'h0000, 16'h8000, 1, 1, "R3 abs 0000 local");
    // R4 register relative with wrap (R6)
    step(1, 2'b01, 2'b10, 16'h0000, 16'h0020, 16'h01F0, 0, 1, "R4 R6 reg rel local wrap");
    step(1, 2'b01, 2'b10, 16'h0000, 16'h0020, 16'hFFF0, 1, 1, "R4 R6 reg rel shared wrap");
    // R5 register absolute, imm misleading
    step(1, 2'b01, 2'b11, 16'h0100, 16'hFFFF, 16'h0010, 0, 1, "R5 reg abs shared");
    step(1, 2'b01, 2'b11, 16'h0300, 16'h01FF, 16'h5000, 1, 1, "R5 reg abs local");
    // R6 sequential wrap
    step(1, 2'b00, 2'b00, 16'h0000, 16'h0000, 16'h01FF, 0, 1, "R6 seq local wrap");
    step(1, 2'b00, 2'b00, 16'h0000, 16'h0000, 16'hFFFF, 1, 1, "R6 seq shared wrap");
    // R7 condition fail leaves stack alone
    step(1, 2'b01, 2'b01, 16'h0100, 16'h0000, 16'h1234, 1, 0, "R7 jump cond fail");
    step(1, 2'b10, 2'b01, 16'h2000, 16'h0000, 16'h0050, 0, 1, "R8 call");
    step(1, 2'b10, 2'b01, 16'h0100, 16'h0000, 16'h2000, 1, 0, "R7 call cond fail");
    step(1, 2'b11, 2'b00, 16'h0000, 16'h0000, 16'h2001, 1, 1, "R7 R8 ret after skipped call");
    // R8 mixed-mode chain
    step(1, 2'b10, 2'b01, 16'h4000, 16'h0000, 16'h0040, 0, 1, "R8 call local to shared");
    step(1, 2'b10, 2'b01, 16'h0100, 16'h0000, 16'h4010, 1, 1, "R8 call shared to local");
    step(1, 2'b11, 2'b00, 16'h0000, 16'h0000, 16'h0105, 0, 1, "R8 ret to shared");
    // R11 idle hold
    step(0, 2'b01, 2'b01, 16'h0000, 16'h0000, 16'h0000, 0, 1, "R11 idle hold");
    step(1, 2'b11, 2'b00, 16'h0000, 16'h0000, 16'h4011, 1, 1, "R8 ret to local");
    // R9 overflow: five calls, five returns
    for (int i = 0; i < 5; i++)
      step(1, 2'b10, 2'b01, 16'h6000, 16'h0000, 16'(16'h1000 + i), 1, 1, "R9 call fill");
    for (int i = 0; i < 4; i++)
      step(1, 2'b11, 2'b00, 16'h0000, 16'h0000, 16'h6000, 1, 1, "R9 ret order");
    step(1, 2'b11, 2'b00, 16'h0000, 16'h0000, 16'h6000, 1, 1, "R10 empty pop");
    step(1, 2'b01, 2'b01, 16'h0400, 16'h0000, 16'h0000, 0, 1, "R10 sticky flag");
    step(0, 2'b11, 2'b00, 16'h0000, 16'h0000, 16'h0000, 0, 1, "R11 idle after ret");

    // Random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 7) != 0), o, 2'($urandom_range(0, 3)),
           16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 5) != 0),
           (o == 2'b11) ? "R8 random ret" : (o == 2'b10) ? "R9 random call" : "R2 random mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule